// File: doc/BRIEF.md
# Bridge Configuration Header Register File

This block holds the 64-byte configuration header of a PCI-to-PCI bridge (header type 1) as synthesizable storage. A host-side configuration engine presents one request per cycle carrying a byte address, an access size of 1, 2 or 4 bytes, write data and a write flag. The block answers one cycle later with registered read data and an error flag.

Every bit of every header dword has one attribute: writable, read-only, write-1-to-clear or reserved. Bits that are neither writable, write-1-to-clear nor reserved are read-only. A write is a read-modify-write of the addressed dword. It is limited to the byte lanes the access covers, and it obeys these attributes. Reserved bits always read as zero.

Each accepted write also emits a one-cycle notify pulse. The pulse carries the dword index, the value before the write, the value after it and the lane mask, so that neighbouring logic can react to changes in bus numbers, windows or control bits. A build-time option removes all writable bits from the prefetchable window dword.

Top module: `cfghdr_regfile`

## Requirements
- R1: After a synchronous reset, dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 1 reads 0x0010_0000 (capabilities-list status bit 20 set). Dword 2 reads {24'h060400, REV_ID}. Dword 3 reads 0x0001_0010 (header type 1 in bits 23:16, cache line size 0x10 in bits 7:0). All other dwords read zero, and rsp_valid and wn_valid are low.
- R2: Sizes 1, 2 and 4 are legal. Any other size gives rsp_err=1 and rsp_rdata=0 one cycle later, with no notify pulse and no change to any dword.
- R3: A request gives rsp_valid one cycle later. A read first clears the dword's reserved bits. A size-4 read then returns the whole dword, whatever the offset. A size-1 or size-2 read returns the dword shifted right by 8×addr[1:0], masked to 8 or 16 bits.
- R4: The lane mask is 0xFFFF_FFFF for size 4. For size 2 it is 0xFFFF shifted left by 8×addr[1:0], and for size 1 it is 0xFF shifted the same way, both truncated to 32 bits.
- R5: Write data is shifted left by 8×addr[1:0] for every size. Then, in this order: bits that are outside the mask or not writable keep their old value; writable bits inside the mask take the shifted data; write-1-to-clear bits inside the mask clear where the shifted data is 1.
- R6: A byte address of 64 or more reads as zero and ignores writes, with no error and no notify pulse.
- R7: Dword 1 (command/status): writable bits are 0, 1, 2, 6 and 8. Write-1-to-clear bits are 24 and 27–31. Reserved bits are 10–15, 16–19 and 22. All other bits are read-only.
- R8: Dwords 0, 2, 3, 4 and 5 are fully read-only. In dword 13, bits 7:0 are read-only (reset 0) and bits 31:8 are reserved.
- R9: Dword 6 bits 23:0 are writable and bits 31:24 are read-only. Dword 7 has writable bits 15:12 and 7:4, write-1-to-clear bits 24 and 27–31, and reserved bits 16–20 and 22. Dwords 8 and 9 have writable bits 31:20 and 15:4. Dwords 10, 11 and 12 are fully writable.
- R10: In dword 14, bits 31:11 and bit 0 are writable and bits 10:1 are reserved. In dword 15, bits 7:0 and bridge-control bits 16–19, 21, 22, 24, 25 and 27 are writable. Bit 26 is write-1-to-clear. Bits 20 and 28–31 are reserved. Bits 15:8 and 23 are read-only.
- R11: With NO_PREF=1, dword 9 has no writable bits and reads zero after any write.
- R12: Each legal in-range write raises wn_valid for one cycle, one cycle after the request. The pulse carries wn_index = addr[5:2], wn_old (the read value before the write), wn_new (the merged value) and wn_mask (the R4 lane mask). Reads, errored requests and out-of-range writes raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address into configuration space |
| req_size | input | SIZE_W | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data, unshifted |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Illegal access size |
| wn_valid | output | 1 | Write notify pulse |
| wn_index | output | 4 | Dword index of the notified write |
| wn_old | output | 32 | Dword value before the write |
| wn_new | output | 32 | Dword value after the write |
| wn_mask | output | 32 | Byte-lane mask of the write |

## Verification
The assertions assume a request is sampled only in cycles where req_valid is high, and that req_valid stays low while reset is asserted. Under that assumption each response traces back to exactly one request of the previous cycle. The bench holds each request for a single cycle, drives it between clock edges and releases reset with the bus idle. It sweeps every dword, every size and every byte offset, including word offset 3, where the lane mask is truncated. The sizes it applies are both legal and illegal, and its addresses cover both sides of the 64-byte boundary within the address width.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

  localparam int HDR_DWORDS = 16;
  localparam int HDR_BYTES  = HDR_DWORDS * 4;
  localparam int DW_IDX_W   = $clog2(HDR_DWORDS);

  // Bits not covered by any field are read-only.
  typedef struct packed {
    logic [31:0] rw;
    logic [31:0] w1c;
    logic [31:0] rsvd;
  } bit_attr_t;

  function automatic bit_attr_t attr_for(input int idx, input bit no_pref);
    bit_attr_t a;
    a = '0;
    case (idx)
      1: begin
        a.rw   = 32'h0000_0147;
        a.w1c  = 32'hF900_0000;
        a.rsvd = 32'h004F_FC00;
      end
      6:  a.rw = 32'h00FF_FFFF;
      7: begin
        a.rw   = 32'h0000_F0F0;
        a.w1c  = 32'hF900_0000;
        a.rsvd = 32'h005F_0000;
      end
      8:  a.rw = 32'hFFF0_FFF0;
      9:  a.rw = no_pref ? 32'h0000_0000 : 32'hFFF0_FFF0;
      10, 11, 12: a.rw = 32'hFFFF_FFFF;
      13: a.rsvd = 32'hFFFF_FF00;
      14: begin
        a.rw   = 32'hFFFF_F801;
        a.rsvd = 32'h0000_07FE;
      end
      15: begin
        a.rw   = 32'h0B6F_00FF;
        a.w1c  = 32'h0400_0000;
        a.rsvd = 32'hF010_0000;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [31:0] reset_for(input int idx, input logic [15:0] ven,
                                            input logic [15:0] dev, input logic [7:0] rev);
    case (idx)
      0:       return {dev, ven};
      1:       return 32'h0010_0000;
      2:       return {24'h060400, rev};
      3:       return 32'h0001_0010;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/cfghdr_decode.sv
module cfghdr_decode
  import cfghdr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [SIZE_W-1:0]   req_size,
  output logic [DW_IDX_W-1:0] dw_idx,
  output logic [4:0]          bit_shift,
  output logic [31:0]         lane_mask,
  output logic                in_range,
  output logic                size_ok
);

  assign dw_idx    = req_addr[DW_IDX_W+1:2];
  assign bit_shift = {req_addr[1:0], 3'b000};
  assign in_range  = (req_addr < ADDR_W'(HDR_BYTES));

  always_comb begin
    size_ok   = 1'b1;
    lane_mask = 32'h0000_0000;
    case (req_size)
      SIZE_W'(1): lane_mask = 32'h0000_00FF << bit_shift;
      SIZE_W'(2): lane_mask = 32'h0000_FFFF << bit_shift;
      SIZE_W'(4): lane_mask = 32'hFFFF_FFFF;
      default:    size_ok   = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfghdr_wmerge.sv
module cfghdr_wmerge (
  input  logic [31:0] old_val,
  input  logic [31:0] wdata,
  input  logic [4:0]  bit_shift,
  input  logic [31:0] lane_mask,
  input  logic [31:0] rw_bits,
  input  logic [31:0] w1c_bits,
  output logic [31:0] new_val
);

  logic [31:0] sdata;
  assign sdata = wdata << bit_shift;

  always_comb begin
    new_val = old_val & ~(rw_bits & lane_mask);
    new_val = new_val | (sdata & rw_bits & lane_mask);
    new_val = new_val & ~(sdata & w1c_bits & lane_mask);
  end

endmodule

// File: rtl/cfghdr_rlane.sv
module cfghdr_rlane #(
  parameter int SIZE_W = 3
) (
  input  logic [31:0]       dw_val,
  input  logic [4:0]        bit_shift,
  input  logic [SIZE_W-1:0] req_size,
  output logic [31:0]       lane_data
);

  logic [31:0] shifted;
  assign shifted = dw_val >> bit_shift;

  always_comb begin
    case (req_size)
      SIZE_W'(1): lane_data = shifted & 32'h0000_00FF;
      SIZE_W'(2): lane_data = shifted & 32'h0000_FFFF;
      default:    lane_data = dw_val;
    endcase
  end

endmodule

// File: rtl/cfghdr_regfile.sv
module cfghdr_regfile
  import cfghdr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          SIZE_W    = 3,
  parameter logic [15:0] VENDOR_ID = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID = 16'h3C4D,
  parameter logic [7:0]  REV_ID    = 8'h05,
  parameter bit          NO_PREF   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              wn_valid,
  output logic [3:0]        wn_index,
  output logic [31:0]       wn_old,
  output logic [31:0]       wn_new,
  output logic [31:0]       wn_mask
);

  logic [DW_IDX_W-1:0] dw_idx;
  logic [4:0]          bit_shift;
  logic [31:0]         lane_mask;
  logic                in_range;
  logic                size_ok;

  cfghdr_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_decode (
    .req_addr (req_addr),
    .req_size (req_size),
    .dw_idx   (dw_idx),
    .bit_shift(bit_shift),
    .lane_mask(lane_mask),
    .in_range (in_range),
    .size_ok  (size_ok)
  );

  bit_attr_t [HDR_DWORDS-1:0]   attr_arr;
  logic [HDR_DWORDS-1:0][31:0]  dw_q;
  logic                         accept;
  logic                         wr_fire;
  logic [31:0]                  old_val;
  logic [31:0]                  new_val;
  logic [31:0]                  rd_lane;

  assign accept  = req_valid & size_ok & in_range;
  assign wr_fire = accept & req_write;
  assign old_val = dw_q[dw_idx] & ~attr_arr[dw_idx].rsvd;

  cfghdr_wmerge u_wmerge (
    .old_val  (old_val),
    .wdata    (req_wdata),
    .bit_shift(bit_shift),
    .lane_mask(lane_mask),
    .rw_bits  (attr_arr[dw_idx].rw),
    .w1c_bits (attr_arr[dw_idx].w1c),
    .new_val  (new_val)
  );

  cfghdr_rlane #(.SIZE_W(SIZE_W)) u_rlane (
    .dw_val   (old_val),
    .bit_shift(bit_shift),
    .req_size (req_size),
    .lane_data(rd_lane)
  );

  // One storage dword per header slot; attributes fixed at elaboration.
  for (genvar gi = 0; gi < HDR_DWORDS; gi++) begin : g_dw
    localparam bit_attr_t   ATTR = attr_for(gi, NO_PREF);
    localparam logic [31:0] RSTV = reset_for(gi, VENDOR_ID, DEVICE_ID, REV_ID);
    logic [31:0] q;

    always_ff @(posedge clk) begin
      if (rst)
        q <= RSTV;
      else if (wr_fire && (dw_idx == DW_IDX_W'(gi)))
        q <= new_val;
    end

    assign attr_arr[gi] = ATTR;
    assign dw_q[gi]     = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      wn_valid  <= 1'b0;
      wn_index  <= '0;
      wn_old    <= '0;
      wn_new    <= '0;
      wn_mask   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & ~size_ok;
      rsp_rdata <= (accept && !req_write) ? rd_lane : 32'h0;
      wn_valid  <= wr_fire;
      if (wr_fire) begin
        wn_index <= 4'(dw_idx);
        wn_old   <= old_val;
        wn_new   <= new_val;
        wn_mask  <= lane_mask;
      end
    end
  end

endmodule

// File: rtl/cfghdr_regfile_chk.sv
module cfghdr_regfile_chk
  import cfghdr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              wn_valid,
  input logic [31:0]       wn_old,
  input logic [31:0]       wn_new,
  input logic [31:0]       wn_mask
);

  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r3_rsp_has_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  a_r12_notify_from_write: assert property (@(posedge clk) disable iff (rst)
    wn_valid |-> $past(req_valid && req_write));

  a_r5_outside_lanes_kept: assert property (@(posedge clk) disable iff (rst)
    wn_valid |-> (((wn_new ^ wn_old) & ~wn_mask) == 32'h0));

  a_r2_err_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (!wn_valid && rsp_rdata == 32'h0));

  a_r6_oor_read_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr >= ADDR_W'(HDR_BYTES)) |=> (rsp_rdata == 32'h0));

  a_r4_mask_width: assert property (@(posedge clk) disable iff (rst)
    wn_valid |-> ($countones(wn_mask) == 8 || $countones(wn_mask) == 16 ||
                  $countones(wn_mask) == 32));

endmodule

bind cfghdr_regfile cfghdr_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err),
  .wn_valid (wn_valid),
  .wn_old   (wn_old),
  .wn_new   (wn_new),
  .wn_mask  (wn_mask)
);

// File: tb/cfghdr_regfile_bench.sv
module cfghdr_regfile_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;

  logic        rsp_valid, rsp_err, wn_valid;
  logic [31:0] rsp_rdata, wn_old, wn_new, wn_mask;
  logic [3:0]  wn_index;

  logic        n_rsp_valid, n_rsp_err, n_wn_valid;
  logic [31:0] n_rsp_rdata, n_wn_old, n_wn_new, n_wn_mask;
  logic [3:0]  n_wn_index;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [31:0] mdl [16];

  always #10 clk = ~clk;

  cfghdr_regfile u_cfghdr_regfile (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .wn_valid(wn_valid), .wn_index(wn_index), .wn_old(wn_old),
    .wn_new(wn_new), .wn_mask(wn_mask)
  );

  cfghdr_regfile #(.NO_PREF(1'b1)) u_cfghdr_regfile_np (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(n_rsp_valid), .rsp_rdata(n_rsp_rdata), .rsp_err(n_rsp_err),
    .wn_valid(n_wn_valid), .wn_index(n_wn_index), .wn_old(n_wn_old),
    .wn_new(n_wn_new), .wn_mask(n_wn_mask)
  );

  function automatic logic [31:0] b_rw(input int i);
    case (i)
      1:          return 32'h0000_0147;
      6:          return 32'h00FF_FFFF;
      7:          return 32'h0000_F0F0;
      8, 9:       return 32'hFFF0_FFF0;
      10, 11, 12: return 32'hFFFF_FFFF;
      14:         return 32'hFFFF_F801;
      15:         return 32'h0B6F_00FF;
      default:    return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] b_w1c(input int i);
    case (i)
      1, 7:    return 32'hF900_0000;
      15:      return 32'h0400_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] b_rsvd(input int i);
    case (i)
      1:       return 32'h004F_FC00;
      7:       return 32'h005F_0000;
      13:      return 32'hFFFF_FF00;
      14:      return 32'h0000_07FE;
      15:      return 32'hF010_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      1:          return "R7";
      6, 7, 8, 9, 10, 11, 12: return "R9";
      14, 15:     return "R10";
      default:    return "R8";
    endcase
  endfunction

  function automatic logic [31:0] exp_mask(input int sz, input int off);
    if (sz == 4) return 32'hFFFF_FFFF;
    if (sz == 2) return 32'h0000_FFFF << (8 * off);
    return 32'h0000_00FF << (8 * off);
  endfunction

  function automatic logic [31:0] exp_read(input int i, input int sz, input int off);
    logic [31:0] v;
    v = mdl[i] & ~b_rsvd(i);
    if (sz == 1) return (v >> (8 * off)) & 32'hFF;
    if (sz == 2) return (v >> (8 * off)) & 32'hFFFF;
    return v;
  endfunction

  function automatic logic [31:0] exp_merge(input int i, input int off, input logic [31:0] m,
                                            input logic [31:0] d);
    logic [31:0] o, sd, n;
    o  = mdl[i] & ~b_rsvd(i);
    sd = d << (8 * off);
    n  = o & ~(b_rw(i) & m);
    n  = n | (sd & b_rw(i) & m);
    n  = n & ~(sd & b_w1c(i) & m);
    return n;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_size  = sz;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'h5A3C_96E1;
    pats[2] = 32'hA5C3_691E;
    pats[3] = 32'h0000_0000;

    for (int i = 0; i < 16; i++) mdl[i] = 32'h0;
    mdl[0] = {16'h3C4D, 16'h1A2B};
    mdl[1] = 32'h0010_0000;
    mdl[2] = {24'h060400, 8'h05};
    mdl[3] = 32'h0001_0010;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk("R1", "wn_valid after reset", 32'(wn_valid), 32'h0);
    for (int i = 0; i < 16; i++) begin
      do_req(1'b0, 8'(i * 4), 3'd4, 32'h0);
      chk("R1", $sformatf("reset dword %0d", i), rsp_rdata, exp_read(i, 4, 0));
      chk("R3", "rsp_valid on read", 32'(rsp_valid), 32'h1);
    end

    // Sweep every dword, size and byte offset with several data patterns.
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 16; i++) begin
        for (int s = 0; s < 3; s++) begin
          for (int o = 0; o < 4; o++) begin
            int sz;
            int r;
            logic [31:0] d, m, nv, ov;
            sz = (s == 0) ? 1 : (s == 1) ? 2 : 4;
            r  = (i * 3 + o + s) % 32;
            d  = (pats[p] << r) | (pats[p] >> (32 - r));
            if (r == 0) d = pats[p];
            m  = exp_mask(sz, o);
            ov = mdl[i] & ~b_rsvd(i);
            nv = exp_merge(i, o, m, d);
            do_req(1'b1, 8'(i * 4 + o), 3'(sz), d);
            chk("R12", "wn_valid on write", 32'(wn_valid), 32'h1);
            chk("R12", "wn_index", 32'(wn_index), 32'(i));
            chk("R4", $sformatf("lane mask size %0d off %0d", sz, o), wn_mask, m);
            chk("R12", "wn_old", wn_old, ov);
            chk({"R5/", tag_of(i)}, $sformatf("merged dword %0d", i), wn_new, nv);
            chk("R2", "no error on legal write", 32'(rsp_err), 32'h0);
            mdl[i] = nv;
            do_req(1'b0, 8'(i * 4 + o), 3'(sz), 32'h0);
            chk({"R3/", tag_of(i)}, $sformatf("read dword %0d size %0d off %0d", i, sz, o),
                rsp_rdata, exp_read(i, sz, o));
            chk("R12", "no notify on read", 32'(wn_valid), 32'h0);
          end
        end
      end
    end

    // Illegal sizes on a writable dword.
    do_req(1'b1, 8'd24, 3'd4, 32'hFFFF_FFFF);
    mdl[6] = exp_merge(6, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int z = 0; z < 8; z++) begin
      if (z == 1 || z == 2 || z == 4) continue;
      do_req(1'b1, 8'd24, 3'(z), 32'h0);
      chk("R2", $sformatf("err on size %0d", z), 32'(rsp_err), 32'h1);
      chk("R2", "no notify on bad size", 32'(wn_valid), 32'h0);
      do_req(1'b0, 8'd25, 3'(z), 32'h0);
      chk("R2", "bad-size read data zero", rsp_rdata, 32'h0);
      chk("R2", "bad-size read err", 32'(rsp_err), 32'h1);
    end
    do_req(1'b0, 8'd24, 3'd4, 32'h0);
    chk("R2", "dword 6 unchanged after bad sizes", rsp_rdata, exp_read(6, 4, 0));

    // Beyond the header end.
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a;
      a = (k == 0) ? 8'd64 : (k == 1) ? 8'd100 : (k == 2) ? 8'd152 : 8'd255;
      do_req(1'b1, a, 3'd4, 32'h0);
      chk("R6", "no notify out of range", 32'(wn_valid), 32'h0);
      chk("R6", "no error out of range", 32'(rsp_err), 32'h0);
      do_req(1'b0, a, 3'd4, 32'h0);
      chk("R6", $sformatf("read zero at %0d", a), rsp_rdata, 32'h0);
    end
    do_req(1'b0, 8'd24, 3'd4, 32'h0);
    chk("R6", "dword 6 unchanged after out-of-range writes", rsp_rdata, exp_read(6, 4, 0));

    // Prefetchable window option.
    do_req(1'b1, 8'd36, 3'd4, 32'hFFFF_FFFF);
    chk("R11", "np notify keeps old", n_wn_new, n_wn_old);
    do_req(1'b0, 8'd36, 3'd4, 32'h0);
    chk("R9", "pref window writable by default", rsp_rdata, 32'hFFF0_FFF0);
    chk("R11", "pref window read-only with option", n_rsp_rdata, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule